// File: doc/BRIEF.md
# Embedded-Sync Video Byte Filter

This block sits on an 8-bit digital video stream in the 4:2:2 component byte format, where line and field timing travels inside the data as four-byte timing codes rather than on separate sync pins. Each timing code is a reserved preamble of one FF byte and two 00 bytes, followed by a status byte. The status byte carries the field, vertical-blanking and horizontal-blanking flags, plus four protection bits. The block watches every byte accepted under the pixel-clock enable. It keeps the current field and blanking state and passes ordinary data bytes to a downstream write port with a one-cycle valid strobe.

Three configuration inputs narrow what reaches the write port. The first removes every byte received during horizontal or vertical blanking, so memory holds only picture data. The second keeps only even-indexed or only odd-indexed samples of each line, which separates chroma (even) from luma (odd). The third discards one field, or both. Timing-code bytes never reach the write port, and a status byte that fails its protection check is dropped without changing state.

Top module: `vsf_sync_filter`

## Requirements
- R1: After reset, out_valid is 0, fld is 0, vblank is 1 and hblank is 1.
- R2: A timing code is an FF byte, then two 00 bytes, then a status byte. None of these four bytes is ever forwarded, and an FF byte is never forwarded under any condition.
- R3: A valid status byte sets fld from bit 6, vblank from bit 5 and hblank from bit 4. The new values show on the outputs in the clock after the status byte is accepted. H=0 marks start of active video (SAV) and H=1 marks end of active video (EAV); for example 80 is SAV in field 0, 9D is EAV in field 0, C7 is SAV in field 1 and DA is EAV in field 1.
- R4: A status byte is valid only when bit 7 is 1 and bits 3..0 equal {V^H, F^H, F^V, F^V^H}. An invalid status byte leaves fld, vblank and hblank unchanged and is not forwarded.
- R5: A data byte accepted with pix_en high appears on out_byte with out_valid high in the next clock, unless a filter below drops it. A cycle with pix_en low gives out_valid low in the next clock.
- R6: With cfg_skip_blank=1, data bytes received while vblank or hblank is 1 are dropped. With cfg_skip_blank=0 they are forwarded.
- R7: Each data byte has a line index. The index is 0 for the first data byte after a valid SAV code and rises by one for each later data byte; timing-code bytes do not advance it. A data byte with an even index passes only if cfg_keep_phase bit 0 is 1, and one with an odd index passes only if bit 1 is 1.
- R8: A data byte received while fld is 0 is dropped when cfg_drop_fld bit 0 is 1. A data byte received while fld is 1 is dropped when cfg_drop_fld bit 1 is 1.
- R9: If an FF, or an FF followed by 00, is followed by a byte that does not continue the preamble, the preamble bytes are still dropped. The breaking byte is handled as an ordinary data byte and advances the line index, and the search for a preamble starts again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_en | input | 1 | Qualifies pix_byte in this cycle |
| pix_byte | input | 8 | Incoming stream byte |
| cfg_skip_blank | input | 1 | Drop bytes received during blanking |
| cfg_keep_phase | input | 2 | Bit 0 keeps even-index samples, bit 1 keeps odd-index samples |
| cfg_drop_fld | input | 2 | Bit 0 drops field 0, bit 1 drops field 1 |
| out_valid | output | 1 | Write strobe for out_byte |
| out_byte | output | 8 | Forwarded data byte |
| fld | output | 1 | Current field flag |
| vblank | output | 1 | Current vertical-blanking flag |
| hblank | output | 1 | Current horizontal-blanking flag |

## Verification
Every result of the block is due exactly one clock after the accepting edge. A forwarded byte, the drop decision for it, and a state change from a status byte all come out of single registers. The bench applies each byte and its configuration on a falling edge, lets one rising edge pass, and compares out_valid, out_byte, fld, vblank and hblank at the following falling edge, before it applies the next byte. The filter decision is taken from the state held before the byte arrived, so each table row gives the expected state after that row's byte.

// File: rtl/vsf_pkg.sv
package vsf_pkg;

  localparam int unsigned BYTE_W = 8;
  localparam logic [BYTE_W-1:0] LEAD_BYTE = 8'hFF;
  localparam logic [BYTE_W-1:0] FILL_BYTE = 8'h00;

  typedef struct packed {
    logic f;
    logic v;
    logic h;
  } vsf_tstate_t;

  // Status byte protection: marker bit set and parity nibble consistent.
  function automatic logic vsf_code_ok(input logic [BYTE_W-1:0] s);
    logic f, v, h;
    f = s[6];
    v = s[5];
    h = s[4];
    return s[7] && (s[3:0] == {v ^ h, f ^ h, f ^ v, f ^ v ^ h});
  endfunction

  function automatic vsf_tstate_t vsf_decode(input logic [BYTE_W-1:0] s);
    vsf_tstate_t t;
    t.f = s[6];
    t.v = s[5];
    t.h = s[4];
    return t;
  endfunction

  // Forwarding decision for one data byte.
  function automatic logic vsf_pass(input vsf_tstate_t t,
                                    input logic        odd_idx,
                                    input logic        skip_blank,
                                    input logic [1:0]  keep_phase,
                                    input logic [1:0]  drop_fld);
    logic in_blank, phase_ok, field_ok;
    in_blank = t.v | t.h;
    phase_ok = odd_idx ? keep_phase[1] : keep_phase[0];
    field_ok = t.f ? !drop_fld[1] : !drop_fld[0];
    return phase_ok && field_ok && !(skip_blank && in_blank);
  endfunction

endpackage

// File: rtl/vsf_trs_match.sv
module vsf_trs_match
  import vsf_pkg::*;
#(
  parameter int unsigned PRE_LEN = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pix_en,
  input  logic [BYTE_W-1:0] pix_byte,
  output logic              is_code_byte,
  output logic              status_stb
);

  localparam int unsigned CNT_W = $clog2(PRE_LEN + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(PRE_LEN);

  logic [CNT_W-1:0] seen_q, seen_d;

  always_comb begin
    is_code_byte = 1'b0;
    status_stb   = 1'b0;
    seen_d       = '0;
    if (seen_q == FULL) begin
      is_code_byte = 1'b1;
      status_stb   = 1'b1;
    end else if (pix_byte == LEAD_BYTE) begin
      is_code_byte = 1'b1;
      seen_d       = CNT_W'(1);
    end else if (seen_q != '0 && pix_byte == FILL_BYTE) begin
      is_code_byte = 1'b1;
      seen_d       = seen_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      seen_q <= '0;
    else if (pix_en) seen_q <= seen_d;
  end

endmodule

// File: rtl/vsf_timing.sv
module vsf_timing
  import vsf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              code_take,
  input  logic [BYTE_W-1:0] pix_byte,
  output vsf_tstate_t       tstate,
  output logic              code_ok,
  output logic              sav_stb
);

  vsf_tstate_t nxt;

  always_comb begin
    code_ok = vsf_code_ok(pix_byte);
    nxt     = vsf_decode(pix_byte);
    sav_stb = code_take && code_ok && !nxt.h;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                    tstate <= '{f: 1'b0, v: 1'b1, h: 1'b1};
    else if (code_take && code_ok) tstate <= nxt;
  end

endmodule

// File: rtl/vsf_sample_gate.sv
module vsf_sample_gate
  import vsf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              data_stb,
  input  logic              sav_stb,
  input  logic [BYTE_W-1:0] pix_byte,
  input  vsf_tstate_t       tstate,
  input  logic              cfg_skip_blank,
  input  logic [1:0]        cfg_keep_phase,
  input  logic [1:0]        cfg_drop_fld,
  output logic              out_valid,
  output logic [BYTE_W-1:0] out_byte
);

  logic odd_q;
  logic fwd;

  assign fwd = data_stb &&
               vsf_pass(tstate, odd_q, cfg_skip_blank, cfg_keep_phase, cfg_drop_fld);

  always_ff @(posedge clk) begin
    if (!rst_n)        odd_q <= 1'b0;
    else if (sav_stb)  odd_q <= 1'b0;
    else if (data_stb) odd_q <= ~odd_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_byte  <= '0;
    end else begin
      out_valid <= fwd;
      if (fwd) out_byte <= pix_byte;
    end
  end

endmodule

// File: rtl/vsf_sync_filter.sv
module vsf_sync_filter
  import vsf_pkg::*;
#(
  parameter int unsigned PRE_LEN = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pix_en,
  input  logic [BYTE_W-1:0] pix_byte,
  input  logic              cfg_skip_blank,
  input  logic [1:0]        cfg_keep_phase,
  input  logic [1:0]        cfg_drop_fld,
  output logic              out_valid,
  output logic [BYTE_W-1:0] out_byte,
  output logic              fld,
  output logic              vblank,
  output logic              hblank
);

  logic        is_code_byte;
  logic        status_stb;
  logic        code_take;
  logic        code_ok;
  logic        sav_stb;
  logic        data_stb;
  vsf_tstate_t tstate;

  vsf_trs_match #(.PRE_LEN(PRE_LEN)) u_match (
    .clk          (clk),
    .rst_n        (rst_n),
    .pix_en       (pix_en),
    .pix_byte     (pix_byte),
    .is_code_byte (is_code_byte),
    .status_stb   (status_stb)
  );

  assign code_take = pix_en && status_stb;
  assign data_stb  = pix_en && !is_code_byte;

  vsf_timing u_timing (
    .clk       (clk),
    .rst_n     (rst_n),
    .code_take (code_take),
    .pix_byte  (pix_byte),
    .tstate    (tstate),
    .code_ok   (code_ok),
    .sav_stb   (sav_stb)
  );

  vsf_sample_gate u_gate (
    .clk            (clk),
    .rst_n          (rst_n),
    .data_stb       (data_stb),
    .sav_stb        (sav_stb),
    .pix_byte       (pix_byte),
    .tstate         (tstate),
    .cfg_skip_blank (cfg_skip_blank),
    .cfg_keep_phase (cfg_keep_phase),
    .cfg_drop_fld   (cfg_drop_fld),
    .out_valid      (out_valid),
    .out_byte       (out_byte)
  );

  assign fld    = tstate.f;
  assign vblank = tstate.v;
  assign hblank = tstate.h;

endmodule

// File: rtl/vsf_sync_filter_chk.sv
module vsf_sync_filter_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       pix_en,
  input logic [7:0] pix_byte,
  input logic       cfg_skip_blank,
  input logic [1:0] cfg_drop_fld,
  input logic       out_valid,
  input logic [7:0] out_byte,
  input logic       fld,
  input logic       vblank,
  input logic       hblank,
  input logic       code_take,
  input logic       code_ok
);

  assert_valid_has_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(pix_en));

  assert_byte_echo_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_byte == $past(pix_byte));

  assert_no_lead_byte_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_byte != 8'hFF);

  assert_state_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (code_take && code_ok) |=>
      {fld, vblank, hblank} == {$past(pix_byte[6]), $past(pix_byte[5]), $past(pix_byte[4])});

  assert_bad_code_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (code_take && !code_ok) |=> $stable({fld, vblank, hblank}));

  assert_blank_skipped_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(cfg_skip_blank)) |-> (!$past(vblank) && !$past(hblank)));

  assert_field_dropped_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !($past(fld) ? $past(cfg_drop_fld[1]) : $past(cfg_drop_fld[0])));

endmodule

bind vsf_sync_filter vsf_sync_filter_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .pix_en         (pix_en),
  .pix_byte       (pix_byte),
  .cfg_skip_blank (cfg_skip_blank),
  .cfg_drop_fld   (cfg_drop_fld),
  .out_valid      (out_valid),
  .out_byte       (out_byte),
  .fld            (fld),
  .vblank         (vblank),
  .hblank         (hblank),
  .code_take      (code_take),
  .code_ok        (code_ok)
);

// File: tb/vsf_sync_filter_bench.sv
module vsf_sync_filter_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pix_en = 1'b0;
  logic [7:0] pix_byte = 8'h00;
  logic       cfg_skip_blank = 1'b0;
  logic [1:0] cfg_keep_phase = 2'd3;
  logic [1:0] cfg_drop_fld = 2'd0;
  logic       out_valid;
  logic [7:0] out_byte;
  logic       fld, vblank, hblank;

  int checks = 0;
  int failures = 0;
  logic done = 1'b0;

  always #2 clk = ~clk;

  vsf_sync_filter u_vsf_sync_filter (
    .clk            (clk),
    .rst_n          (rst_n),
    .pix_en         (pix_en),
    .pix_byte       (pix_byte),
    .cfg_skip_blank (cfg_skip_blank),
    .cfg_keep_phase (cfg_keep_phase),
    .cfg_drop_fld   (cfg_drop_fld),
    .out_valid      (out_valid),
    .out_byte       (out_byte),
    .fld            (fld),
    .vblank         (vblank),
    .hblank         (hblank)
  );

  // Row: req id[20:17] byte[16:9] skip[8] phase[7:6] drop[5:4] exp_valid[3] exp_fvh[2:0]
  localparam int N = 54;
  localparam logic [20:0] TBL [N] = '{
    {4'd5, 8'h10, 1'b0, 2'd3, 2'd0, 1'b1, 3'b011},
    {4'd2, 8'hFF, 1'b0, 2'd3, 2'd0, 1'b0, 3'b011},
    {4'd2, 8'h00, 1'b0, 2'd3, 2'd0, 1'b0, 3'b011},
    {4'd2, 8'h00, 1'b0, 2'd3, 2'd0, 1'b0, 3'b011},
    {4'd3, 8'h80, 1'b0, 2'd3, 2'd0, 1'b0, 3'b000},
    {4'd5, 8'h11, 1'b0, 2'd3, 2'd0, 1'b1, 3'b000},
    {4'd5, 8'h22, 1'b0, 2'd3, 2'd0, 1'b1, 3'b000},
    {4'd6, 8'h33, 1'b1, 2'd3, 2'd0, 1'b1, 3'b000},
    {4'd2, 8'hFF, 1'b0, 2'd3, 2'd0, 1'b0, 3'b000},
    {4'd2, 8'h00, 1'b0, 2'd3, 2'd0, 1'b0, 3'b000},
    {4'd2, 8'h00, 1'b0, 2'd3, 2'd0, 1'b0, 3'b000},
    {4'd3, 8'h9D, 1'b0, 2'd3, 2'd0, 1'b0, 3'b001},
    {4'd6, 8'h80, 1'b1, 2'd3, 2'd0, 1'b0, 3'b001},
    {4'd6, 8'h10, 1'b0, 2'd3, 2'd0, 1'b1, 3'b001},
    {4'd2, 8'hFF, 1'b0, 2'd3, 2'd0, 1'b0, 3'b001},
    {4'd2, 8'h00, 1'b0, 2'd3, 2'd0, 1'b0, 3'b001},
    {4'd2, 8'h00, 1'b0, 2'd3, 2'd0, 1'b0, 3'b001},
    {4'd4, 8'hC6, 1'b0, 2'd3, 2'd0, 1'b0, 3'b001},
    {4'd4, 8'h10, 1'b1, 2'd3, 2'd0, 1'b0, 3'b001},
    {4'd2, 8'hFF, 1'b0, 2'd3, 2'd0, 1'b0, 3'b001},
    {4'd2, 8'h00, 1'b0, 2'd3, 2'd0, 1'b0, 3'b001},
    {4'd2, 8'h00, 1'b0, 2'd3, 2'd0, 1'b0, 3'b001},
    {4'd3, 8'hC7, 1'b0, 2'd3, 2'd0, 1'b0, 3'b100},
    {4'd7, 8'hA0, 1'b0, 2'd1, 2'd0, 1'b1, 3'b100},
    {4'd7, 8'hA1, 1'b0, 2'd1, 2'd0, 1'b0, 3'b100},
    {4'd7, 8'hA2, 1'b0, 2'd1, 2'd0, 1'b1, 3'b100},
    {4'd7, 8'hA3, 1'b0, 2'd2, 2'd0, 1'b1, 3'b100},
    {4'd7, 8'hA4, 1'b0, 2'd2, 2'd0, 1'b0, 3'b100},
    {4'd8, 8'hA5, 1'b0, 2'd3, 2'd2, 1'b0, 3'b100},
    {4'd8, 8'hA6, 1'b0, 2'd3, 2'd1, 1'b1, 3'b100},
    {4'd9, 8'hFF, 1'b0, 2'd3, 2'd0, 1'b0, 3'b100},
    {4'd9, 8'h00, 1'b0, 2'd3, 2'd0, 1'b0, 3'b100},
    {4'd9, 8'h55, 1'b0, 2'd3, 2'd0, 1'b1, 3'b100},
    {4'd2, 8'hFF, 1'b0, 2'd3, 2'd0, 1'b0, 3'b100},
    {4'd2, 8'h00, 1'b0, 2'd3, 2'd0, 1'b0, 3'b100},
    {4'd2, 8'h00, 1'b0, 2'd3, 2'd0, 1'b0, 3'b100},
    {4'd4, 8'h47, 1'b0, 2'd3, 2'd0, 1'b0, 3'b100},
    {4'd7, 8'hB0, 1'b0, 2'd1, 2'd0, 1'b1, 3'b100},
    {4'd2, 8'hFF, 1'b0, 2'd3, 2'd0, 1'b0, 3'b100},
    {4'd2, 8'h00, 1'b0, 2'd3, 2'd0, 1'b0, 3'b100},
    {4'd2, 8'h00, 1'b0, 2'd3, 2'd0, 1'b0, 3'b100},
    {4'd3, 8'hDA, 1'b0, 2'd3, 2'd0, 1'b0, 3'b101},
    {4'd2, 8'hFF, 1'b0, 2'd3, 2'd0, 1'b0, 3'b101},
    {4'd2, 8'h00, 1'b0, 2'd3, 2'd0, 1'b0, 3'b101},
    {4'd2, 8'h00, 1'b0, 2'd3, 2'd0, 1'b0, 3'b101},
    {4'd3, 8'hEC, 1'b0, 2'd3, 2'd0, 1'b0, 3'b110},
    {4'd7, 8'hC0, 1'b0, 2'd1, 2'd0, 1'b1, 3'b110},
    {4'd7, 8'hC1, 1'b0, 2'd1, 2'd0, 1'b0, 3'b110},
    {4'd6, 8'hC2, 1'b1, 2'd3, 2'd0, 1'b0, 3'b110},
    {4'd2, 8'hFF, 1'b0, 2'd3, 2'd0, 1'b0, 3'b110},
    {4'd2, 8'h00, 1'b0, 2'd3, 2'd0, 1'b0, 3'b110},
    {4'd2, 8'h00, 1'b0, 2'd3, 2'd0, 1'b0, 3'b110},
    {4'd3, 8'hF1, 1'b0, 2'd3, 2'd0, 1'b0, 3'b111},
    {4'd8, 8'h10, 1'b0, 2'd3, 2'd1, 1'b1, 3'b111}
  };

  function automatic string req_name(input logic [3:0] id);
    case (id)
      4'd1: return "R1";
      4'd2: return "R2";
      4'd3: return "R3";
      4'd4: return "R4";
      4'd5: return "R5";
      4'd6: return "R6";
      4'd7: return "R7";
      4'd8: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic check(input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic [7:0] b, input logic skip,
                       input logic [1:0] ph, input logic [1:0] drop);
    pix_en = 1'b1;
    pix_byte = b;
    cfg_skip_blank = skip;
    cfg_keep_phase = ph;
    cfg_drop_fld = drop;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: state held in reset
    check("R1", "out_valid", {7'd0, out_valid}, 8'h00);
    check("R1", "fvh", {5'd0, fld, vblank, hblank}, 8'h03);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "out_valid after release", {7'd0, out_valid}, 8'h00);

    for (int i = 0; i < N; i++) begin
      drive(TBL[i][16:9], TBL[i][8], TBL[i][7:6], TBL[i][5:4]);
      @(negedge clk);
      check(req_name(TBL[i][20:17]), $sformatf("row %0d valid", i),
            {7'd0, out_valid}, {7'd0, TBL[i][3]});
      if (TBL[i][3])
        check(req_name(TBL[i][20:17]), $sformatf("row %0d byte", i),
              out_byte, TBL[i][16:9]);
      check(req_name(TBL[i][20:17]), $sformatf("row %0d fvh", i),
            {5'd0, fld, vblank, hblank}, {5'd0, TBL[i][2:0]});
    end

    // R5: idle cycle gives no strobe
    pix_en = 1'b0;
    pix_byte = 8'h42;
    @(negedge clk);
    check("R5", "valid on idle", {7'd0, out_valid}, 8'h00);

    // R2 and R9: a lone FF is dropped, the next byte is data
    drive(8'hFF, 1'b0, 2'd3, 2'd0);
    @(negedge clk);
    check("R2", "lone FF dropped", {7'd0, out_valid}, 8'h00);
    drive(8'h3C, 1'b0, 2'd3, 2'd0);
    @(negedge clk);
    check("R9", "byte after lone FF valid", {7'd0, out_valid}, 8'h01);
    check("R9", "byte after lone FF", out_byte, 8'h3C);

    // R1: reset returns the initial state
    rst_n = 1'b0;
    pix_en = 1'b0;
    @(negedge clk);
    check("R1", "fvh after second reset", {5'd0, fld, vblank, hblank}, 8'h03);
    check("R1", "valid after second reset", {7'd0, out_valid}, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    finish_run();
  end

endmodule